// File: doc/BRIEF.md
# Transmit Dominant Time-out Guard

This block sits between the host's transmit-data line and the enable of the bus low-side driver. A low level on transmit data asks for a dominant bus. A high level, which is also what the pull-up gives on an open line, leaves the bus recessive. The guard passes the host's request through in the same cycle. It also keeps a count of how long the line has been held low. If the line stays low too long, the guard forces the driver off, so that a stuck host or a broken wire cannot hold the whole bus dominant.

Once tripped, the guard does not let go on the first high sample. Transmit data must stay high for a full release window of consecutive cycles before the driver can be enabled again. A high glitch that is shorter than the window therefore leaves the driver off. A status flag is high for as long as the guard is tripped. The driver can only be active while the mode input says the interface is in normal operation. Leaving normal operation returns the guard to its idle, armed state.

Both windows are parameters counted in clock cycles. The transmit-data input is expected to be synchronized to the clock already.

Top module: `domguard_top`

## Requirements
- R1: In normal mode and not tripped, `drvEn` is 1 in the same cycle that `txData` is 0, and `drvEn` is 0 whenever `txData` is 1.
- R2: With `txData` held at 0 in normal mode from an armed state, `drvEn` stays 1 for exactly `DOM_LIMIT` clock cycles. On the `DOM_LIMIT`-th rising edge that samples 0, the guard trips and `drvEn` drops to 0.
- R3: Any clock edge that samples `txData` at 1 clears the low-run count. Two low runs of fewer than `DOM_LIMIT` cycles each, separated by one high cycle, never trip the guard.
- R4: While tripped, the guard releases on the `REL_LIMIT`-th consecutive rising edge that samples `txData` at 1. After release, a 0 on `txData` drives `drvEn` to 1 again.
- R5: While tripped, a high run shorter than `REL_LIMIT` cycles followed by a 0 does not release the guard. That 0 restarts the high-run count.
- R6: `timeoutFlag` is 1 exactly while the guard is tripped: from the tripping edge until the releasing edge. `drvEn` is 0 whenever `timeoutFlag` is 1.
- R7: With `normalMode` at 0, `drvEn` is 0. After one clock edge in that mode, the low count, the high count and the trip state are all cleared, so `timeoutFlag` is 0. Low cycles spent outside normal mode do not count toward a trip.
- R8: While `rstN` is 0, the guard is armed with both counts cleared and `timeoutFlag` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txData | input | 1 | Synchronized host transmit data; 0 requests a dominant bus |
| normalMode | input | 1 | 1 when the interface is in normal operation |
| drvEn | output | 1 | Low-side driver enable; 1 pulls the bus dominant |
| timeoutFlag | output | 1 | 1 while the dominant time-out has tripped |

## Verification
The bench drives low runs of every length from 1 to `DOM_LIMIT`+2 cycles. An off-by-one in the trip compare would let the driver stay on one cycle too long, or cut it off one cycle early. After a trip, it sweeps high pulses from 1 to `REL_LIMIT`+1 cycles. A design that released on the first high sample, or did not clear its high count when a low arrives, would turn the driver back on after a short glitch. It also splits a long low time with a single high cycle, which exposes a low counter that fails to clear. It holds the line low outside normal mode, which exposes a counter that keeps running or a flag that survives a mode exit.

// File: rtl/domguard_pkg.sv
package domguard_pkg;

  // Strobes from the control to the counter datapath.
  typedef struct packed {
    logic lowInc;
    logic lowClr;
    logic highInc;
    logic highClr;
  } cntStrobe_t;

  typedef enum logic {
    ST_ARMED   = 1'b0,
    ST_TRIPPED = 1'b1
  } guardState_t;

endpackage

// File: rtl/domguard_counters.sv
module domguard_counters
  import domguard_pkg::*;
#(
  parameter int DOM_LIMIT = 6000,
  parameter int REL_LIMIT = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  cntStrobe_t strobe,
  output logic       lowDone,
  output logic       highDone
);

  localparam int LOW_W = $clog2(DOM_LIMIT + 1);
  localparam int HIGH_W = $clog2(REL_LIMIT + 1);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(DOM_LIMIT - 1);
  localparam logic [HIGH_W-1:0] HIGH_LAST = HIGH_W'(REL_LIMIT - 1);

  logic [LOW_W-1:0]  lowCnt;
  logic [HIGH_W-1:0] highCnt;

  // Number of consecutive low samples seen so far.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
    end else if (strobe.lowClr) begin
      lowCnt <= '0;
    end else if (strobe.lowInc) begin
      lowCnt <= lowCnt + 1'b1;
    end
  end

  // Number of consecutive high samples seen while tripped.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCnt <= '0;
    end else if (strobe.highClr) begin
      highCnt <= '0;
    end else if (strobe.highInc) begin
      highCnt <= highCnt + 1'b1;
    end
  end

  assign lowDone  = (lowCnt == LOW_LAST);
  assign highDone = (highCnt == HIGH_LAST);

  AST_LOW_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= LOW_LAST) else $error("low count past its window"); // R2

  AST_HIGH_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    highCnt <= HIGH_LAST) else $error("high count past its window"); // R4

  AST_LOW_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lowClr |=> lowCnt == '0) else $error("low count not cleared"); // R3

  AST_HIGH_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.highClr |=> highCnt == '0) else $error("high count not cleared"); // R5

endmodule

// File: rtl/domguard_ctrl.sv
module domguard_ctrl
  import domguard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txData,
  input  logic       normalMode,
  input  logic       lowDone,
  input  logic       highDone,
  output cntStrobe_t strobe,
  output logic       drvEn,
  output logic       timeoutFlag
);

  guardState_t state;
  guardState_t nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    if (!normalMode) begin
      strobe.lowClr  = 1'b1;
      strobe.highClr = 1'b1;
      nextState      = ST_ARMED;
    end else begin
      case (state)
        ST_ARMED: begin
          strobe.highClr = 1'b1;
          if (!txData) begin
            if (lowDone) begin
              nextState     = ST_TRIPPED;
              strobe.lowClr = 1'b1;
            end else begin
              strobe.lowInc = 1'b1;
            end
          end else begin
            strobe.lowClr = 1'b1;
          end
        end
        ST_TRIPPED: begin
          strobe.lowClr = 1'b1;
          if (txData) begin
            if (highDone) begin
              nextState      = ST_ARMED;
              strobe.highClr = 1'b1;
            end else begin
              strobe.highInc = 1'b1;
            end
          end else begin
            strobe.highClr = 1'b1;
          end
        end
        default: nextState = ST_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_ARMED;
    end else begin
      state <= nextState;
    end
  end

  assign timeoutFlag = (state == ST_TRIPPED);
  assign drvEn       = normalMode && !txData && (state == ST_ARMED);

  AST_TRIP_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> $past(!txData && normalMode)) else $error("trip without low"); // R2

  AST_RELEASE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(timeoutFlag) && $past(normalMode)) |-> $past(txData)) else $error("release on low"); // R5

  AST_FLAG_BLOCKS_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |-> !drvEn) else $error("driver on while tripped"); // R6

  AST_MODE_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !normalMode |=> !timeoutFlag) else $error("flag survives mode exit"); // R7

endmodule

// File: rtl/domguard_top.sv
module domguard_top
  import domguard_pkg::*;
#(
  parameter int DOM_LIMIT = 6000,
  parameter int REL_LIMIT = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic txData,
  input  logic normalMode,
  output logic drvEn,
  output logic timeoutFlag
);

  cntStrobe_t strobe;
  logic       lowDone;
  logic       highDone;

  domguard_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .txData      (txData),
    .normalMode  (normalMode),
    .lowDone     (lowDone),
    .highDone    (highDone),
    .strobe      (strobe),
    .drvEn       (drvEn),
    .timeoutFlag (timeoutFlag)
  );

  domguard_counters #(
    .DOM_LIMIT (DOM_LIMIT),
    .REL_LIMIT (REL_LIMIT)
  ) u_counters (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lowDone  (lowDone),
    .highDone (highDone)
  );

  AST_HIGH_NEVER_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    txData |-> !drvEn) else $error("driver on with high data"); // R1

  AST_DRIVE_ONLY_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    drvEn |-> normalMode) else $error("driver on outside normal mode"); // R7

endmodule

// File: tb/sim_domguard_top.sv
module sim_domguard_top;

  localparam int CLK_PERIOD = 10;
  localparam int DOM = 8;
  localparam int REL = 4;
  localparam int WATCHDOG_CYCLES = 50000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txData = 1'b1;
  logic normalMode = 1'b1;
  logic drvEn;
  logic timeoutFlag;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  domguard_top #(.DOM_LIMIT(DOM), .REL_LIMIT(REL)) u0 (
    .clk(clk), .rstN(rstN), .txData(txData), .normalMode(normalMode),
    .drvEn(drvEn), .timeoutFlag(timeoutFlag)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  // Drive new inputs just after a falling edge; outputs settle before the next rising edge.
  task automatic drive(input logic tx, input logic m);
    @(negedge clk);
    txData = tx;
    normalMode = m;
    #1;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    // R8 reset state
    txData = 1'b1;
    normalMode = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(timeoutFlag, 1'b0, "R8 flag in reset");
    chk(drvEn, 1'b0, "R8 drive in reset");
    @(negedge clk);
    rstN = 1'b1;

    // R1 R2 R6: sweep of low-run lengths
    for (int len = 1; len <= DOM + 2; len++) begin
      drive(1'b1, 1'b0);
      drive(1'b1, 1'b1);
      chk(drvEn, 1'b0, "R1 high data no drive");
      for (int k = 0; k < len; k++) begin
        drive(1'b0, 1'b1);
        chk(drvEn, (k < DOM) ? 1'b1 : 1'b0, "R2 drive during low run");
        chk(timeoutFlag, (k >= DOM) ? 1'b1 : 1'b0, "R6 flag during low run");
      end
      drive(1'b1, 1'b1);
      chk(timeoutFlag, (len >= DOM) ? 1'b1 : 1'b0, "R6 flag after low run");
      chk(drvEn, 1'b0, "R1 high after run");
      // R7 leaving normal mode clears trip
      drive(1'b1, 1'b0);
      drive(1'b1, 1'b1);
      chk(timeoutFlag, 1'b0, "R7 flag after mode exit");
    end

    // R3 one high sample splits two sub-limit low runs
    drive(1'b1, 1'b0);
    for (int k = 0; k < DOM - 1; k++) begin
      drive(1'b0, 1'b1);
      chk(drvEn, 1'b1, "R3 first run");
    end
    drive(1'b1, 1'b1);
    chk(timeoutFlag, 1'b0, "R3 no trip after split");
    for (int k = 0; k <= DOM; k++) begin
      drive(1'b0, 1'b1);
      chk(drvEn, (k < DOM) ? 1'b1 : 1'b0, "R3 second run restarts count");
    end

    // R4 R5: high pulses of each length after a trip
    for (int h = 1; h <= REL + 1; h++) begin
      drive(1'b1, 1'b0);
      for (int k = 0; k <= DOM; k++) drive(1'b0, 1'b1);
      chk(timeoutFlag, 1'b1, "R6 tripped before release sweep");
      for (int j = 0; j < h; j++) begin
        drive(1'b1, 1'b1);
        chk(timeoutFlag, (j < REL) ? 1'b1 : 1'b0, "R4 flag during high run");
        chk(drvEn, 1'b0, "R1 high run no drive");
      end
      drive(1'b0, 1'b1);
      chk(timeoutFlag, (h < REL) ? 1'b1 : 1'b0, "R5 glitch vs release flag");
      chk(drvEn, (h < REL) ? 1'b0 : 1'b1, "R4 drive after high run");
      if (h < REL) begin
        // R5 the low sample restarted the high count: REL-1 highs must not release
        for (int j = 0; j < REL - 1; j++) drive(1'b1, 1'b1);
        drive(1'b0, 1'b1);
        chk(timeoutFlag, 1'b1, "R5 high count restarted");
      end
    end

    // R7 low outside normal mode does not count and never drives
    drive(1'b1, 1'b0);
    for (int k = 0; k < DOM + 2; k++) begin
      drive(1'b0, 1'b0);
      chk(drvEn, 1'b0, "R7 no drive outside normal");
      chk(timeoutFlag, 1'b0, "R7 no trip outside normal");
    end
    for (int k = 0; k <= DOM; k++) begin
      drive(1'b0, 1'b1);
      chk(drvEn, (k < DOM) ? 1'b1 : 1'b0, "R7 fresh window on mode entry");
    end
    drive(1'b0, 1'b0);
    chk(timeoutFlag, 1'b1, "R7 flag held until edge");
    drive(1'b0, 1'b1);
    chk(timeoutFlag, 1'b0, "R7 flag cleared by mode exit");
    chk(drvEn, 1'b1, "R7 drive after mode re-entry");

    finishRun();
  end

endmodule